// File: doc/BRIEF.md
# Scintillation Pulse Parameter Extractor

This block watches a single stream of digitized photodetector samples, one sample per clock, and turns each physics event into a compact four-word record. It subtracts a programmable baseline from every sample, compares the result against a programmable threshold, and treats a run of samples above the threshold as a pulse. The first pulse of an event (the prompt light) is integrated and its width counted. The block then waits a bounded number of samples for a second, delayed pulse, integrates that one too, and measures the quiet gap between the two.

Quiet samples outside an event never produce output, so only event records leave the block. Each record carries a time stamp from a free-running sample counter. A run-reset input shared by all channels restarts that counter, so records from different channels can be lined up in time. A finished record waits at a valid/ready handshake. While it waits, incoming samples are discarded and no new event starts.

Top module: `scint_pulse_extractor`

## Requirements
- R1: A sample word carries the converter value in bits 13:0 and an overflow flag in bit 14; bit 15 is unused. A sample is above threshold only when value minus baseline is strictly greater than the threshold. A sample at or below the baseline is never above threshold.
- R2: Record word 0 (rec_o[15:0]) holds the sum of (value minus baseline) over the first pulse. The sum is saturated in a wider internal register and clipped to 0xFFFF.
- R3: A second pulse is accepted when the number of below-threshold samples separating it from the first pulse is between 1 and max_gap_i inclusive. Its area goes to word 1 (rec_o[31:16]) and that separation count goes to the gap field, word 2 bits 7:0 (rec_o[39:32]).
- R4: The record is emitted with word 1 equal to 0 and the gap field equal to 0xFF in either of two cases: the first pulse is followed by max_gap_i+1 consecutive below-threshold samples, or max_gap_i is 0. In the timeout case rec_valid_o rises in the cycle after the (max_gap_i+1)-th below sample is taken. max_gap_i must not exceed 254.
- R5: Word 2 bits 14:8 (rec_o[46:40]) hold the first pulse's width in samples, saturating at 127.
- R6: Word 2 bit 15 (rec_o[47]) is set when any sample inside either pulse has the overflow flag set.
- R7: Word 3 (rec_o[63:48]) holds the time stamp of the first sample of the first pulse. The stamp counter advances by one every clock. A clock with run_rst_i high makes the next clock's sample carry stamp 0.
- R8: Streams that never exceed the threshold produce no record.
- R9: While rec_valid_o is high and rec_ready_i is low, rec_o stays unchanged and incoming samples are discarded: no new event starts. The record is consumed on a clock where both are high, and rec_valid_o is low in the following cycle.
- R10: After reset rec_valid_o is low and the stamp counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, one sample per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_rst_i | input | 1 | Synchronous restart of the stamp counter |
| sample_i | input | 16 | Sample word: value in 13:0, overflow in 14 |
| baseline_i | input | 14 | Baseline subtracted from each sample |
| threshold_i | input | 14 | Pulse threshold over the baseline |
| max_gap_i | input | 8 | Longest accepted separation, in samples |
| rec_valid_o | output | 1 | Record pending |
| rec_ready_i | input | 1 | Consumer accepts the record |
| rec_o | output | 64 | Four-word event record |

## Verification
The bench drives several stream types, each aimed at a different failure.

- Purely quiet streams with values at, below and just under the threshold show whether the strict comparison and the handling of negative baseline differences are right.
- A single pulse followed by silence shows whether the timeout fires on the correct sample and whether the first-pulse fields are right.
- A pulse pair separated by exactly the maximum gap, and another pair separated by more than it, show whether the accept boundary is placed correctly and whether a late pulse starts a fresh event.
- Long full-scale pulses, overflow-flagged samples and a stalled consumer exercise saturation, clipping, the flag bit and the freeze of a pending record.

// File: rtl/spx_pkg.sv
package spx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_P1,
    S_WAIT,
    S_P2,
    S_HOLD
  } spx_state_e;
endpackage

// File: rtl/spx_detect.sv
// Baseline subtraction and threshold compare.
module spx_detect #(
  parameter int ADC_W = 14,
  parameter int SMP_W = 16
) (
  input  logic [SMP_W-1:0] sample_i,
  input  logic [ADC_W-1:0] baseline_i,
  input  logic [ADC_W-1:0] threshold_i,
  output logic             above_o,
  output logic             ovf_o,
  output logic [ADC_W-1:0] excess_o
);
  logic [ADC_W:0] diff;
  logic           unused_hi;

  assign diff      = {1'b0, sample_i[ADC_W-1:0]} - {1'b0, baseline_i};
  assign above_o   = !diff[ADC_W] && (diff[ADC_W-1:0] > threshold_i);
  assign ovf_o     = sample_i[ADC_W];
  assign excess_o  = diff[ADC_W-1:0];
  assign unused_hi = ^sample_i[SMP_W-1:ADC_W];
endmodule

// File: rtl/spx_accum.sv
// Saturating area accumulator with clipped narrow view.
module spx_accum #(
  parameter int IN_W  = 14,
  parameter int ACC_W = 20,
  parameter int OUT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ld_i,
  input  logic             add_i,
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] clip_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc_q} + (ACC_W+1)'(val_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (ld_i)   acc_q <= ACC_W'(val_i);
    else if (add_i)  acc_q <= sum[ACC_W] ? '1 : sum[ACC_W-1:0];
  end

  assign clip_o = (|acc_q[ACC_W-1:OUT_W]) ? '1 : acc_q[OUT_W-1:0];
endmodule

// File: rtl/spx_stamp.sv
// Free-running sample stamp, restarted by run reset.
module spx_stamp #(
  parameter int TS_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_rst_i,
  output logic [TS_W-1:0] ts_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ts_o <= '0;
    else if (run_rst_i) ts_o <= '0;
    else                ts_o <= ts_o + 1'b1;
  end
endmodule

// File: rtl/scint_pulse_extractor.sv
module scint_pulse_extractor
  import spx_pkg::*;
#(
  parameter int ADC_W  = 14,
  parameter int SMP_W  = 16,
  parameter int ACC_W  = 20,
  parameter int WORD_W = 16,
  parameter int WID_W  = 7,
  localparam int GAP_W = WORD_W - 1 - WID_W,
  localparam int REC_W = 4 * WORD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_rst_i,
  input  logic [SMP_W-1:0] sample_i,
  input  logic [ADC_W-1:0] baseline_i,
  input  logic [ADC_W-1:0] threshold_i,
  input  logic [GAP_W-1:0] max_gap_i,
  output logic             rec_valid_o,
  input  logic             rec_ready_i,
  output logic [REC_W-1:0] rec_o
);
  spx_state_e        state_q;
  logic              above, ovf;
  logic [ADC_W-1:0]  excess;
  logic [WORD_W-1:0] ts_now, ts_cap_q;
  logic [WID_W-1:0]  width_q;
  logic [GAP_W-1:0]  gcnt_q, gap_q;
  logic              sat_q;
  logic [WORD_W-1:0] area_w [2];
  logic [1:0]        clr_a, ld_a, add_a;

  spx_detect #(.ADC_W(ADC_W), .SMP_W(SMP_W)) u_det (
    .sample_i    (sample_i),
    .baseline_i  (baseline_i),
    .threshold_i (threshold_i),
    .above_o     (above),
    .ovf_o       (ovf),
    .excess_o    (excess)
  );

  spx_stamp #(.TS_W(WORD_W)) u_ts (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_rst_i (run_rst_i),
    .ts_o      (ts_now)
  );

  // area 0: prompt pulse, area 1: delayed pulse
  assign clr_a[0] = 1'b0;
  assign ld_a[0]  = (state_q == S_IDLE) && above;
  assign add_a[0] = (state_q == S_P1) && above;
  assign clr_a[1] = (state_q == S_IDLE) && above;
  assign ld_a[1]  = (state_q == S_WAIT) && above;
  assign add_a[1] = (state_q == S_P2) && above;

  for (genvar g = 0; g < 2; g++) begin : g_area
    spx_accum #(.IN_W(ADC_W), .ACC_W(ACC_W), .OUT_W(WORD_W)) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_a[g]),
      .ld_i   (ld_a[g]),
      .add_i  (add_a[g]),
      .val_i  (excess),
      .clip_o (area_w[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      width_q  <= '0;
      sat_q    <= 1'b0;
      gcnt_q   <= '0;
      gap_q    <= '0;
      ts_cap_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (above) begin
          state_q  <= S_P1;
          width_q  <= WID_W'(1);
          sat_q    <= ovf;
          ts_cap_q <= ts_now;
        end
        S_P1: if (above) begin
          if (width_q != '1) width_q <= width_q + 1'b1;
          sat_q <= sat_q | ovf;
        end else if (max_gap_i == '0) begin
          gap_q   <= '1;
          state_q <= S_HOLD;
        end else begin
          gcnt_q  <= GAP_W'(1);
          state_q <= S_WAIT;
        end
        S_WAIT: if (above) begin
          gap_q   <= gcnt_q;
          sat_q   <= sat_q | ovf;
          state_q <= S_P2;
        end else if (gcnt_q >= max_gap_i) begin
          gap_q   <= '1;
          state_q <= S_HOLD;
        end else begin
          gcnt_q <= gcnt_q + 1'b1;
        end
        S_P2: if (above) sat_q <= sat_q | ovf;
              else       state_q <= S_HOLD;
        S_HOLD: if (rec_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rec_valid_o = (state_q == S_HOLD);
  assign rec_o = {ts_cap_q, sat_q, width_q, gap_q, area_w[1], area_w[0]};
endmodule

// File: rtl/spx_checker.sv
module spx_checker #(
  parameter int WORD_W = 16,
  parameter int WID_W  = 7,
  localparam int GAP_W = WORD_W - 1 - WID_W,
  localparam int REC_W = 4 * WORD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_rst_i,
  input logic              rec_valid_i,
  input logic              rec_ready_i,
  input logic [REC_W-1:0]  rec_i,
  input logic [GAP_W-1:0]  max_gap_i,
  input logic [WORD_W-1:0] ts_i
);
  logic [GAP_W-1:0]  gap;
  logic [WID_W-1:0]  width;
  logic [WORD_W-1:0] area2;

  assign gap   = rec_i[2*WORD_W +: GAP_W];
  assign width = rec_i[2*WORD_W+GAP_W +: WID_W];
  assign area2 = rec_i[WORD_W +: WORD_W];

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i && !rec_ready_i |=> rec_valid_i && $stable(rec_i));

  p_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i && rec_ready_i |=> !rec_valid_i);

  p_no_second_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i && (gap == '1) |-> area2 == '0);

  p_gap_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i && (gap != '1) |-> (gap != '0) && (gap <= max_gap_i));

  p_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i |-> width != '0);

  p_ts_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_rst_i |=> ts_i == '0);

  p_ts_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_rst_i |=> ts_i == $past(ts_i) + 1'b1);
endmodule

bind scint_pulse_extractor spx_checker #(.WORD_W(WORD_W), .WID_W(WID_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_rst_i   (run_rst_i),
  .rec_valid_i (rec_valid_o),
  .rec_ready_i (rec_ready_i),
  .rec_i       (rec_o),
  .max_gap_i   (max_gap_i),
  .ts_i        (ts_now)
);

// File: tb/tb_scint_pulse_extractor.sv
module tb_scint_pulse_extractor;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_rst = 1'b0;
  logic [15:0] smp = 16'd0;
  logic [13:0] base = 14'd100;
  logic [13:0] thr = 14'd50;
  logic [7:0]  max_gap = 8'd5;
  logic        ready = 1'b1;
  logic        valid;
  logic [63:0] rec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [63:0] got_q[$];

  always #2.5 clk = ~clk;

  scint_pulse_extractor dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .run_rst_i   (run_rst),
    .sample_i    (smp),
    .baseline_i  (base),
    .threshold_i (thr),
    .max_gap_i   (max_gap),
    .rec_valid_o (valid),
    .rec_ready_i (ready),
    .rec_o       (rec)
  );

  always @(negedge clk)
    if (rst_ni && valid && ready) got_q.push_back(rec);

  function automatic logic [63:0] mk(input logic [15:0] ts, input logic sat,
                                     input logic [6:0] w, input logic [7:0] gap,
                                     input logic [15:0] a2, input logic [15:0] a1);
    return {ts, sat, w, gap, a2, a1};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] s);
    smp = s;
    @(posedge clk);
    #1;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) step(16'(base));
  endtask

  task automatic restart_run();
    run_rst = 1'b1;
    step(16'(base));
    run_rst = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 valid after reset", 64'(valid), 64'd0);
    check("R10 no record after reset", 64'(got_q.size()), 64'd0);
  endtask

  task automatic t_quiet();
    got_q.delete();
    for (int i = 0; i < 40; i++) begin
      case (i % 4)
        0: step(16'd150);   // excess equals threshold
        1: step(16'd0);     // far below baseline
        2: step(16'd120);
        default: step(16'd99);
      endcase
    end
    quiet(10);
    check("R8 R1 quiet stream no record", 64'(got_q.size()), 64'd0);
  endtask

  task automatic t_single();
    got_q.delete();
    restart_run();
    quiet(3);
    step(16'd160); step(16'd300); step(16'd180);
    step(16'd150);  // not above: excess == threshold
    quiet(4);
    check("R4 valid not before timeout", 64'(valid), 64'd0);
    quiet(1);
    check("R4 valid at timeout", 64'(valid), 64'd1);
    quiet(10);
    check("R2 single pulse count", 64'(got_q.size()), 64'd1);
    if (got_q.size() > 0)
      check("R2 R5 R7 single pulse record", got_q[0], mk(16'd3, 1'b0, 7'd3, 8'hFF, 16'd0, 16'd340));
  endtask

  task automatic t_pair();
    got_q.delete();
    restart_run();
    quiet(2);
    step(16'd160); step(16'd170);
    for (int i = 0; i < 5; i++) step(16'd120);   // gap exactly max_gap
    step(16'd200); step(16'd200); step(16'd200);
    quiet(10);
    check("R3 pair count", 64'(got_q.size()), 64'd1);
    if (got_q.size() > 0)
      check("R3 pair record", got_q[0], mk(16'd2, 1'b0, 7'd2, 8'd5, 16'd300, 16'd130));
  endtask

  task automatic t_far();
    got_q.delete();
    restart_run();
    quiet(1);
    step(16'd160);
    quiet(8);                 // longer than max_gap
    step(16'd190);
    quiet(10);
    check("R4 far pair count", 64'(got_q.size()), 64'd2);
    if (got_q.size() > 1) begin
      check("R4 first alone", got_q[0], mk(16'd1, 1'b0, 7'd1, 8'hFF, 16'd0, 16'd60));
      check("R7 late pulse new event", got_q[1], mk(16'd10, 1'b0, 7'd1, 8'hFF, 16'd0, 16'd90));
    end
  endtask

  task automatic t_zero_gap();
    got_q.delete();
    max_gap = 8'd0;
    restart_run();
    step(16'd200);
    step(16'd100);
    check("R4 zero gap immediate", 64'(valid), 64'd1);
    quiet(10);
    check("R4 zero gap record", got_q.size() > 0 ? got_q[0] : 64'hx,
          mk(16'd0, 1'b0, 7'd1, 8'hFF, 16'd0, 16'd100));
    max_gap = 8'd5;
  endtask

  task automatic t_ovf();
    got_q.delete();
    restart_run();
    step(16'h4000 | 16'd160); step(16'd200);
    quiet(10);
    check("R6 overflow flag record", got_q.size() > 0 ? got_q[0] : 64'hx,
          mk(16'd0, 1'b1, 7'd2, 8'hFF, 16'd0, 16'd160));
  endtask

  task automatic t_clip();
    got_q.delete();
    base = 14'd0; thr = 14'd0;
    restart_run();
    for (int i = 0; i < 5; i++) step(16'h3FFF);
    quiet(10);
    check("R2 area clip", got_q.size() > 0 ? got_q[0] : 64'hx,
          mk(16'd0, 1'b0, 7'd5, 8'hFF, 16'd0, 16'hFFFF));
    base = 14'd100; thr = 14'd50;
    quiet(2);
  endtask

  task automatic t_wsat();
    got_q.delete();
    restart_run();
    for (int i = 0; i < 130; i++) step(16'd1100);
    quiet(10);
    check("R5 width saturates", got_q.size() > 0 ? got_q[0] : 64'hx,
          mk(16'd0, 1'b0, 7'd127, 8'hFF, 16'd0, 16'hFFFF));
  endtask

  task automatic t_hold();
    logic [63:0] held;
    got_q.delete();
    ready = 1'b0;
    restart_run();
    step(16'd160);
    quiet(6);
    check("R9 record pending", 64'(valid), 64'd1);
    held = rec;
    step(16'd300); step(16'd300); quiet(8);
    check("R9 valid held", 64'(valid), 64'd1);
    check("R9 record stable", rec, held);
    check("R9 nothing taken while stalled", 64'(got_q.size()), 64'd0);
    ready = 1'b1;
    quiet(1);
    check("R9 valid drops after take", 64'(valid), 64'd0);
    quiet(10);
    check("R9 stalled pulse ignored", 64'(got_q.size()), 64'd1);
    if (got_q.size() > 0)
      check("R9 held record value", got_q[0], mk(16'd0, 1'b0, 7'd1, 8'hFF, 16'd0, 16'd60));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    smp = 16'd100;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    quiet(2);
    t_reset();
    t_quiet();
    t_single();
    t_pair();
    t_far();
    t_zero_gap();
    t_ovf();
    t_clip();
    t_wsat();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule